// File: doc/BRIEF.md
# PHY Link Mode Resolver

This block sets up an Ethernet PHY's auto-negotiation and works out the speed and duplex the link came up with. It does not drive the management serial lines itself. It issues register reads and writes to an MDIO master through a request/done handshake, and it keeps exactly one request in flight. A `start` pulse launches the sequence, which has two parts.

In the setup part, the block sets the restart bit in the control register with a read-modify-write. It then polls the status register until negotiation completes. Next it rebuilds the advertisement register, either from a default capability mask or from a single forced speed/duplex bit. Finally it writes the control register to enable and restart negotiation.

In the sensing part, the block reads the control register, the status register and a vendor status register. From these it derives a 2-bit operating mode, an error flag and a full-duplex control bit. Every abnormal outcome falls back to 100 Mb half duplex with the error flag set.

Top module: `phy_mode_resolver`

## Requirements
- R1: After reset `op_mode` is 2'b01, `err`, `fdx`, `auto_used`, `busy`, `done_o` and `mdio_req` are all 0.
- R2: After `start`, requests are issued in this exact order. A read of register 0 comes first, then a write of register 0 with the read value ORed with 0x0200. Register 1 is then read repeatedly until bit 5 is set. A read of register 4 and a write of register 4 follow, then a write of register 0 with 0x1200. The sequence ends with reads of register 0, register 1 and register 25. `mdio_req` stays high until `mdio_done`, then drops for at least one cycle before the next request.
- R3: With `media_sel` = 0 (auto), the value written to register 4 is the value read from it with bits [8:5] cleared, ORed with `cap_mask`.
- R4: With `media_sel` = 1, 2, 3 or 4, the written register 4 value has bits [8:5] cleared and then bit 5, 6, 7 or 8 set respectively. These select 10 half, 10 full, 100 half and 100 full.
- R5: If bits [8:5] of the new register 4 value are all zero, `cap_mask` is ORed in and `auto_used` becomes 1. This happens, for example, with `media_sel` 5 to 7. `auto_used` is otherwise 1 only for `media_sel` = 0.
- R6: The sensing key is {register 0 bit 8, register 25 bits [1:0]}. Key 3'b010 gives `op_mode` 2'b00 (10 half). Key 3'b110 gives 2'b10 (10 full). Key 3'b001 gives 2'b01 (100 half). Key 3'b101 gives 2'b11 (100 full). In each of these cases `err` is 0. Bit 1 of `op_mode` is duplex and bit 0 is 100 Mb.
- R7: Any other key gives `op_mode` 2'b01 with `err` = 1.
- R8: If sensed register 0 bit 12 or sensed register 1 bit 5 is clear, the result is `op_mode` 2'b01 with `err` = 1, whatever the key.
- R9: If POLL_MAX consecutive reads of register 1 show bit 5 clear, the sequence ends with `op_mode` 2'b01 and `err` = 1, and no further request is issued.
- R10: `fdx` equals `op_mode` bit 1.
- R11: A `start` pulse while `busy` is high is ignored, and `media_sel` is sampled only at the accepted `start`.
- R12: `done_o` pulses for one cycle when the result is ready. `op_mode`, `err` and `auto_used` then hold until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one setup and sensing sequence |
| media_sel | input | 3 | 0 auto, 1 10H, 2 10F, 3 100H, 4 100F, others empty |
| cap_mask | input | 16 | Default advertisement bits |
| mdio_req | output | 1 | Request to the MDIO master, held until done |
| mdio_wr | output | 1 | 1 write, 0 read |
| mdio_reg | output | 5 | PHY register number |
| mdio_wdata | output | 16 | Write data |
| mdio_done | input | 1 | One-cycle completion from the MDIO master |
| mdio_rdata | input | 16 | Read data, valid with `mdio_done` |
| busy | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle result-ready pulse |
| op_mode | output | 2 | {duplex, 100 Mb} |
| err | output | 1 | Resolution failed, fallback applied |
| fdx | output | 1 | Full-duplex control |
| auto_used | output | 1 | Advertisement came from `cap_mask` |

## Verification
The sequence is tried under every media selection. For each one the register 4 write data shows whether the field was cleared, the single forced bit chosen, or the empty-field rule applied. The sensing part gets all four valid keys, keys with the duplex bit set but bad speed bits, and a register 25 value with high bits set to expose any missing mask. It is also run with negotiation enable or completion clear, to tell a key failure from a status failure. A poll that never completes, and a second start pulse during a run, separate the timeout path and the start lockout from normal completion.

// File: rtl/phy_mode_resolver.sv
module phy_mode_resolver #(
  parameter int POLL_MAX = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  media_sel,
  input  logic [15:0] cap_mask,
  output logic        mdio_req,
  output logic        mdio_wr,
  output logic [4:0]  mdio_reg,
  output logic [15:0] mdio_wdata,
  input  logic        mdio_done,
  input  logic [15:0] mdio_rdata,
  output logic        busy,
  output logic        done_o,
  output logic [1:0]  op_mode,
  output logic        err,
  output logic        fdx,
  output logic        auto_used
);

  localparam int          CW        = $clog2(POLL_MAX + 1);
  localparam logic [1:0]  M10H      = 2'b00;
  localparam logic [1:0]  M100H     = 2'b01;
  localparam logic [1:0]  M10F      = 2'b10;
  localparam logic [1:0]  M100F     = 2'b11;
  localparam logic [15:0] ADV_FIELD = 16'h01E0;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_WR0, S_POLL, S_RD4, S_WR4, S_WRN, S_SR0, S_SR1, S_SR25
  } step_t;

  step_t       st;
  logic        req_q;
  logic [2:0]  sel_q;
  logic [15:0] hold;
  logic [15:0] r0_q;
  logic [15:0] r1_q;
  logic [CW-1:0] poll_cnt;

  logic [15:0] force_bit;
  logic [15:0] adv_pre;
  logic [15:0] adv_new;
  logic        adv_empty;
  logic [2:0]  key;
  logic [1:0]  res_mode;
  logic        key_ok;
  logic        neg_ok;

  always_comb begin
    case (sel_q)
      3'd1:    force_bit = 16'h0020;
      3'd2:    force_bit = 16'h0040;
      3'd3:    force_bit = 16'h0080;
      3'd4:    force_bit = 16'h0100;
      default: force_bit = 16'h0000;
    endcase
  end

  assign adv_pre   = (mdio_rdata & ~ADV_FIELD) | ((sel_q == 3'd0) ? cap_mask : force_bit);
  assign adv_empty = (adv_pre[8:5] == 4'd0);
  assign adv_new   = adv_empty ? (adv_pre | cap_mask) : adv_pre;

  assign key    = {r0_q[8], mdio_rdata[1:0]};
  assign neg_ok = r0_q[12] & r1_q[5];

  always_comb begin
    key_ok   = 1'b1;
    res_mode = M100H;
    case (key)
      3'b010:  res_mode = M10H;
      3'b110:  res_mode = M10F;
      3'b001:  res_mode = M100H;
      3'b101:  res_mode = M100F;
      default: key_ok = 1'b0;
    endcase
  end

  always_comb begin
    mdio_wr    = 1'b0;
    mdio_reg   = 5'd0;
    mdio_wdata = 16'h0000;
    case (st)
      S_WR0:  begin mdio_wr = 1'b1; mdio_wdata = hold | 16'h0200; end
      S_POLL: mdio_reg = 5'd1;
      S_RD4:  mdio_reg = 5'd4;
      S_WR4:  begin mdio_wr = 1'b1; mdio_reg = 5'd4; mdio_wdata = hold; end
      S_WRN:  begin mdio_wr = 1'b1; mdio_wdata = 16'h1200; end
      S_SR1:  mdio_reg = 5'd1;
      S_SR25: mdio_reg = 5'd25;
      default: ;
    endcase
  end

  assign mdio_req = req_q;
  assign busy     = (st != S_IDLE);
  assign fdx      = op_mode[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      req_q     <= 1'b0;
      sel_q     <= 3'd0;
      hold      <= 16'h0000;
      r0_q      <= 16'h0000;
      r1_q      <= 16'h0000;
      poll_cnt  <= '0;
      done_o    <= 1'b0;
      op_mode   <= M100H;
      err       <= 1'b0;
      auto_used <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          sel_q     <= media_sel;
          err       <= 1'b0;
          auto_used <= (media_sel == 3'd0);
          poll_cnt  <= '0;
          st        <= S_RD0;
        end
      end else if (!req_q) begin
        req_q <= 1'b1;
      end else if (mdio_done) begin
        req_q <= 1'b0;
        case (st)
          S_RD0: begin hold <= mdio_rdata; st <= S_WR0; end
          S_WR0: st <= S_POLL;
          S_POLL: begin
            if (mdio_rdata[5]) begin
              st <= S_RD4;
            end else if (poll_cnt == CW'(POLL_MAX - 1)) begin
              op_mode <= M100H;
              err     <= 1'b1;
              done_o  <= 1'b1;
              st      <= S_IDLE;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
            end
          end
          S_RD4: begin
            hold <= adv_new;
            if (adv_empty) auto_used <= 1'b1;
            st <= S_WR4;
          end
          S_WR4: st <= S_WRN;
          S_WRN: st <= S_SR0;
          S_SR0: begin r0_q <= mdio_rdata; st <= S_SR1; end
          S_SR1: begin r1_q <= mdio_rdata; st <= S_SR25; end
          S_SR25: begin
            op_mode <= (neg_ok && key_ok) ? res_mode : M100H;
            err     <= !(neg_ok && key_ok);
            done_o  <= 1'b1;
            st      <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/phy_mode_resolver_chk.sv
module phy_mode_resolver_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdio_req,
  input logic        mdio_done,
  input logic        mdio_wr,
  input logic [4:0]  mdio_reg,
  input logic [15:0] mdio_wdata,
  input logic        busy,
  input logic        done_o,
  input logic [1:0]  op_mode,
  input logic        err,
  input logic        auto_used
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && !mdio_done) |=> mdio_req);  // R2

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && mdio_done) |=> !mdio_req);  // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_req);  // R9

  AST_EMPTY_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && mdio_wr && mdio_reg == 5'd4 && mdio_wdata[8:5] == 4'd0) |-> auto_used);  // R5

  AST_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err) |-> (op_mode == 2'b01));  // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R12

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(op_mode) && $stable(err)));  // R12

endmodule

bind phy_mode_resolver phy_mode_resolver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdio_req(mdio_req), .mdio_done(mdio_done),
  .mdio_wr(mdio_wr), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
  .busy(busy), .done_o(done_o), .op_mode(op_mode), .err(err),
  .auto_used(auto_used)
);

// File: tb/phy_mode_resolver_tb_top.sv
module phy_mode_resolver_tb_top;
  localparam int PM  = 6;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  media_sel = 3'd0;
  logic [15:0] cap_mask = 16'h0000;
  logic        mdio_req, mdio_wr;
  logic [4:0]  mdio_reg;
  logic [15:0] mdio_wdata;
  logic        mdio_done = 1'b0;
  logic [15:0] mdio_rdata = 16'h0000;
  logic        busy, done_o, err, fdx, auto_used;
  logic [1:0]  op_mode;

  always #4 clk = ~clk;

  phy_mode_resolver #(.POLL_MAX(PM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .media_sel(media_sel),
    .cap_mask(cap_mask), .mdio_req(mdio_req), .mdio_wr(mdio_wr),
    .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_done(mdio_done),
    .mdio_rdata(mdio_rdata), .busy(busy), .done_o(done_o),
    .op_mode(op_mode), .err(err), .fdx(fdx), .auto_used(auto_used)
  );

  int checks = 0;
  int fails  = 0;

  logic [21:0] exp_q[$];
  string       tag_q[$];

  logic [15:0] m_r0, m_r4, m_s0, m_s1, m_r25;
  int          m_poll_n;
  int          m_r1_cnt = 0;
  bit          m_sense = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic wr, input logic [4:0] rg, input logic [15:0] d, input string tag);
    exp_q.push_back({wr, rg, d});
    tag_q.push_back(tag);
  endtask

  // PHY register model behind the MDIO master
  int rs = 0;
  int rc = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      rs <= 0;
      mdio_done <= 1'b0;
    end else begin
      case (rs)
        0: if (mdio_req) begin rs <= 1; rc <= LAT; end
        1: begin
          if (rc == 0) begin
            mdio_done <= 1'b1;
            rs <= 2;
            if (mdio_wr && mdio_reg == 5'd4) m_sense <= 1'b1;
            case (mdio_reg)
              5'd0:  mdio_rdata <= m_sense ? m_s0 : m_r0;
              5'd1: begin
                if (m_sense) mdio_rdata <= m_s1;
                else begin
                  mdio_rdata <= (m_r1_cnt >= m_poll_n) ? 16'h0020 : 16'h0000;
                  m_r1_cnt <= m_r1_cnt + 1;
                end
              end
              5'd4:  mdio_rdata <= m_r4;
              5'd25: mdio_rdata <= m_r25;
              default: mdio_rdata <= 16'h0000;
            endcase
          end else rc <= rc - 1;
        end
        default: begin mdio_done <= 1'b0; rs <= 0; end
      endcase
    end
  end

  // monitor: pops one expected item per new request
  bit seen = 1'b0;
  always @(negedge clk) begin
    if (rst_n && mdio_req && !seen) begin
      logic [21:0] it;
      string tg;
      seen = 1'b1;
      if (exp_q.size() == 0) begin
        chk("R2 unexpected request", {mdio_wr, mdio_reg}, 32'hFFFF);
      end else begin
        it = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk({tg, " kind/reg"}, {26'd0, mdio_wr, mdio_reg}, {26'd0, it[21:16]});
        if (it[21]) chk({tg, " wdata"}, {16'd0, mdio_wdata}, {16'd0, it[15:0]});
      end
    end else if (!mdio_req) begin
      seen = 1'b0;
    end
  end

  task automatic run_case(
    input string name, input logic [2:0] sel, input logic [15:0] cap,
    input logic [15:0] r0, input logic [15:0] r4, input int poll_n,
    input logic [15:0] s0, input logic [15:0] s1, input logic [15:0] r25,
    input logic [15:0] exp_adv, input string adv_tag,
    input logic [1:0] e_op, input logic e_err, input logic e_auto,
    input string res_tag, input bit restart_mid);
    int n;
    bit got;
    m_r0 = r0; m_r4 = r4; m_s0 = s0; m_s1 = s1; m_r25 = r25;
    m_poll_n = poll_n; m_r1_cnt = 0; m_sense = 1'b0;
    push(1'b0, 5'd0, 16'h0, "R2 rd0");
    push(1'b1, 5'd0, r0 | 16'h0200, "R2 wr0");
    if (poll_n >= PM) begin
      for (int i = 0; i < PM; i++) push(1'b0, 5'd1, 16'h0, "R9 poll");
    end else begin
      for (int i = 0; i <= poll_n; i++) push(1'b0, 5'd1, 16'h0, "R2 poll");
      push(1'b0, 5'd4, 16'h0, "R2 rd4");
      push(1'b1, 5'd4, exp_adv, adv_tag);
      push(1'b1, 5'd0, 16'h1200, "R2 wr 1200");
      push(1'b0, 5'd0, 16'h0, "R2 sense0");
      push(1'b0, 5'd1, 16'h0, "R2 sense1");
      push(1'b0, 5'd25, 16'h0, "R2 sense25");
    end
    @(negedge clk);
    media_sel = sel; cap_mask = cap; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({name, " R2 busy"}, {31'd0, busy}, 32'd1);
    if (restart_mid) begin
      repeat (12) @(negedge clk);
      media_sel = 3'd4; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    got = 1'b0;
    n = 0;
    while (!got && n < 3000) begin
      if (done_o) got = 1'b1;
      else begin @(negedge clk); n++; end
    end
    chk({name, " R12 done seen"}, {31'd0, got}, 32'd1);
    chk({name, " ", res_tag, " op_mode"}, {30'd0, op_mode}, {30'd0, e_op});
    chk({name, " ", res_tag, " err"}, {31'd0, err}, {31'd0, e_err});
    chk({name, " R10 fdx"}, {31'd0, fdx}, {31'd0, e_op[1]});
    chk({name, " R5 auto_used"}, {31'd0, auto_used}, {31'd0, e_auto});
    chk({name, " R2 all requests seen"}, exp_q.size(), 32'd0);
    repeat (5) @(negedge clk);
    chk({name, " R12 done pulse"}, {31'd0, done_o}, 32'd0);
    chk({name, " R12 hold"}, {28'd0, op_mode, err, auto_used}, {28'd0, e_op, e_err, e_auto});
    chk({name, " R9 quiet"}, {30'd0, mdio_req, busy}, 32'd0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset op_mode", {30'd0, op_mode}, 32'd1);
    chk("R1 reset flags", {26'd0, err, fdx, auto_used, busy, done_o, mdio_req}, 32'd0);

    run_case("auto100F", 3'd0, 16'h01E1, 16'h3100, 16'h0DE1, 2, 16'h1100, 16'h0024, 16'h0001,
             16'h0DE1, "R3 adv auto", 2'b11, 1'b0, 1'b1, "R6", 1'b0);
    run_case("f10H", 3'd1, 16'h01E1, 16'h1000, 16'h01E1, 0, 16'h1000, 16'h0020, 16'h0002,
             16'h0021, "R4 adv 10H", 2'b00, 1'b0, 1'b0, "R6", 1'b0);
    run_case("f10F", 3'd2, 16'h01E1, 16'h1000, 16'h05E1, 1, 16'h1100, 16'h0020, 16'h0002,
             16'h0441, "R4 adv 10F", 2'b10, 1'b0, 1'b0, "R6", 1'b0);
    run_case("f100H_lock", 3'd3, 16'h01E1, 16'h1000, 16'h0000, 0, 16'h1000, 16'h0020, 16'hFFF1,
             16'h0080, "R11 adv 100H", 2'b01, 1'b0, 1'b0, "R11", 1'b1);
    run_case("f100F", 3'd4, 16'h01E1, 16'h1000, 16'hFFFF, 3, 16'h1100, 16'h0020, 16'h0001,
             16'hFF1F, "R4 adv 100F", 2'b11, 1'b0, 1'b0, "R6", 1'b0);
    run_case("badsel", 3'd6, 16'h0181, 16'h1000, 16'h01E1, 0, 16'h1100, 16'h0020, 16'h0003,
             16'h0181, "R5 adv empty", 2'b01, 1'b1, 1'b1, "R7", 1'b0);
    run_case("noen", 3'd0, 16'h0001, 16'h1000, 16'h01E0, 0, 16'h0100, 16'h0020, 16'h0001,
             16'h0001, "R5 adv nocap", 2'b01, 1'b1, 1'b1, "R8", 1'b0);
    run_case("nocmp", 3'd3, 16'h01E1, 16'h1000, 16'h0000, 0, 16'h1000, 16'h0000, 16'h0001,
             16'h0080, "R4 adv", 2'b01, 1'b1, 1'b0, "R8", 1'b0);
    run_case("badkey", 3'd4, 16'h01E1, 16'h1000, 16'h0000, 0, 16'h1100, 16'h0020, 16'h0000,
             16'h0100, "R4 adv", 2'b01, 1'b1, 1'b0, "R7", 1'b0);
    run_case("timeout", 3'd3, 16'h01E1, 16'h1000, 16'h0000, 1000, 16'h1000, 16'h0020, 16'h0001,
             16'h0000, "R9", 2'b01, 1'b1, 1'b0, "R9", 1'b0);
    run_case("recover", 3'd0, 16'h0041, 16'h1000, 16'h0000, 1, 16'h1000, 16'h0020, 16'h0002,
             16'h0041, "R3 adv auto", 2'b00, 1'b0, 1'b1, "R6", 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule